// File: doc/BRIEF.md
# Address-Space-Tagged Fully Associative Translation Buffer

This block keeps a small set of virtual-to-physical page translations. Each slot holds a virtual page number, a physical page number, an address-space identifier, a global flag, a read-enable mask and a write-enable mask with one bit per privilege mode, and two fault-on-access flags, one for reads and one for writes. A lookup presents a virtual page number, the current address-space identifier, a page offset and a privilege mode. In the same cycle the block returns hit, the matching slot number, the stored fields, the assembled physical address, and the mask bits selected by the mode.

New translations are written into the slot under a rotating victim pointer. Three invalidate commands are available: drop everything, drop only entries that are not global, or drop the entries that a given page number and identifier would hit. A side port shows the slot under the victim pointer and can step the pointer without writing. Walking page tables, deciding permissions and raising faults are left to the surrounding logic. This block only stores, matches and invalidates entries.

Top module: `tlb_asn_fa`

## Requirements
- R1: A slot hits only when it is valid, its page tag equals `lk_vpn`, and either its global flag is set or its stored identifier equals `lk_asn`. `lk_hit` is combinational in the same cycle.
- R2: When several slots hit, `lk_idx` and all returned fields come from the lowest-numbered one. On a miss, `lk_idx` and every returned field read zero.
- R3: On a hit, `lk_paddr` equals the physical page number concatenated above the 13-bit page offset `lk_ofs`, that is `(ppn << 13) | ofs`.
- R4: `lk_rd_ok` is bit `lk_mode` of the hitting slot's read mask, and `lk_wr_ok` is bit `lk_mode` of its write mask.
- R5: A write (`ins_en`=1 with `cmd`=0) fills the slot given by the victim pointer, replacing its contents and setting it valid. From the next cycle the pointer has advanced by one.
- R6: The victim pointer steps from slot ENTRIES-1 back to slot 0.
- R7: `cmd`=1 (clear all) makes every slot invalid and sets the victim pointer to 0 from the next cycle.
- R8: `cmd`=2 (clear local) invalidates every slot whose global flag is clear. Global slots keep their contents and validity.
- R9: `cmd`=3 (clear by address) invalidates every slot that would hit for `cmd_vpn` and `cmd_asn` under the R1 rule. No other slot changes.
- R10: In a cycle with `cmd` non-zero, `ins_en` and `vic_adv` are ignored. No slot is written by them, and only the R7 reset moves the pointer.
- R11: `vic_idx`, `vic_valid`, `vic_vpn` and `vic_ppn` show the slot under the victim pointer. `vic_adv`=1 with `cmd`=0 steps the pointer without writing. A write and an advance in the same cycle step it once.
- R12: After reset every slot is invalid and the victim pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asn | input | ASN_W | Lookup address-space identifier |
| lk_ofs | input | OFS_W | Page offset of the lookup |
| lk_mode | input | MODE_W | Privilege mode selecting mask bits |
| lk_hit | output | 1 | Lookup hit |
| lk_idx | output | IDX_W | Slot that hit |
| lk_ppn | output | PPN_W | Physical page number of the hit |
| lk_paddr | output | PPN_W+OFS_W | Physical address of the hit |
| lk_glob | output | 1 | Global flag of the hit |
| lk_rmask | output | MODES | Read mask of the hit |
| lk_wmask | output | MODES | Write mask of the hit |
| lk_rd_ok | output | 1 | Read mask bit for lk_mode |
| lk_wr_ok | output | 1 | Write mask bit for lk_mode |
| lk_frd | output | 1 | Fault-on-read flag of the hit |
| lk_fwr | output | 1 | Fault-on-write flag of the hit |
| ins_en | input | 1 | Write a new translation |
| ins_vpn | input | VPN_W | New page tag |
| ins_asn | input | ASN_W | New identifier |
| ins_glob | input | 1 | New global flag |
| ins_ppn | input | PPN_W | New physical page |
| ins_rmask | input | MODES | New read mask |
| ins_wmask | input | MODES | New write mask |
| ins_frd | input | 1 | New fault-on-read flag |
| ins_fwr | input | 1 | New fault-on-write flag |
| cmd | input | 2 | 0 none, 1 clear all, 2 clear local, 3 clear by address |
| cmd_vpn | input | VPN_W | Page for clear by address |
| cmd_asn | input | ASN_W | Identifier for clear by address |
| vic_adv | input | 1 | Step the victim pointer |
| vic_idx | output | IDX_W | Victim pointer |
| vic_valid | output | 1 | Validity of the victim slot |
| vic_vpn | output | VPN_W | Tag of the victim slot |
| vic_ppn | output | PPN_W | Physical page of the victim slot |

## Verification
The assertions assume that `lk_mode` stays below MODES. They also assume that `cmd`, the write inputs and `vic_adv` never carry unknown values while out of reset. The stimulus draws modes only from the legal range and drives every input from defined values at every cycle. Page numbers and identifiers are drawn from small pools, so duplicate tags, global entries shadowing local ones, and clear-by-address hits on several slots at once all occur often.

// File: rtl/tlb_asn_pkg.sv
package tlb_asn_pkg;

   typedef enum logic [1:0] {
      TCMD_NONE  = 2'd0,
      TCMD_ALL   = 2'd1,
      TCMD_LOCAL = 2'd2,
      TCMD_ADDR  = 2'd3
   } tlb_cmd_e;

   function automatic logic tag_hit(input logic vld, input logic glob,
                                    input logic tag_eq, input logic asn_eq);
      return vld && tag_eq && (glob || asn_eq);
   endfunction

endpackage

// File: rtl/tlb_match_vec.sv
module tlb_match_vec
   import tlb_asn_pkg::*;
#(
   parameter int N     = 8,
   parameter int VPN_W = 20,
   parameter int ASN_W = 8
)(
   input  logic [N-1:0]            vld,
   input  logic [N-1:0]            glob,
   input  logic [N-1:0][VPN_W-1:0] tag,
   input  logic [N-1:0][ASN_W-1:0] asn,
   input  logic [VPN_W-1:0]        q_vpn,
   input  logic [ASN_W-1:0]        q_asn,
   output logic [N-1:0]            hit_vec
);
   for (genvar i = 0; i < N; i++) begin : g_cmp
      assign hit_vec[i] = tag_hit(vld[i], glob[i], tag[i] == q_vpn, asn[i] == q_asn);
   end
endmodule

// File: rtl/tlb_first_hit.sv
module tlb_first_hit #(
   parameter int N     = 8,
   parameter int IDX_W = $clog2(N)
)(
   input  logic [N-1:0]     vec,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
      any = |vec;
   end

   // R2: the reported slot really hits and no lower slot does
   always_comb begin
      if (any) begin
         a_r2_lowest_set: assert (vec[idx]);
      end
      for (int j = 0; j < N; j++) begin
         if (any && (j < int'(idx))) begin
            a_r2_none_below: assert (!vec[j]);
         end
      end
   end
endmodule

// File: rtl/tlb_victim_ptr.sv
module tlb_victim_ptr #(
   parameter int N     = 8,
   parameter int IDX_W = $clog2(N)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             step,
   output logic [IDX_W-1:0] ptr
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);
   localparam bit POW2 = (N == (1 << IDX_W));

   logic [IDX_W-1:0] nxt;

   if (POW2) begin : g_pow2
      assign nxt = ptr + 1'b1;
   end else begin : g_cmp
      assign nxt = (ptr == LAST) ? '0 : ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)      ptr <= '0;
      else if (clr)    ptr <= '0;
      else if (step)   ptr <= nxt;
   end

   a_r6_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr && ptr == LAST) |=> ptr == '0);
   a_r7_ptr_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> ptr == '0);
   a_r6_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      ptr <= LAST);
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !clr) |=> $stable(ptr));
endmodule

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
   parameter int N     = 8,
   parameter int VPN_W = 20,
   parameter int PPN_W = 16,
   parameter int ASN_W = 8,
   parameter int MODES = 4,
   parameter int IDX_W = $clog2(N)
)(
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr_all,
   input  logic                    clr_local,
   input  logic [N-1:0]            clr_vec,
   input  logic                    wr_en,
   input  logic [IDX_W-1:0]        wr_idx,
   input  logic [VPN_W-1:0]        wr_vpn,
   input  logic [ASN_W-1:0]        wr_asn,
   input  logic                    wr_glob,
   input  logic [PPN_W-1:0]        wr_ppn,
   input  logic [MODES-1:0]        wr_rmask,
   input  logic [MODES-1:0]        wr_wmask,
   input  logic                    wr_frd,
   input  logic                    wr_fwr,
   output logic [N-1:0]            vld,
   output logic [N-1:0]            glob,
   output logic [N-1:0][VPN_W-1:0] tag,
   output logic [N-1:0][ASN_W-1:0] asn,
   output logic [N-1:0][PPN_W-1:0] ppn,
   output logic [N-1:0][MODES-1:0] rmask,
   output logic [N-1:0][MODES-1:0] wmask,
   output logic [N-1:0]            frd,
   output logic [N-1:0]            fwr
);
   for (genvar i = 0; i < N; i++) begin : g_slot
      logic sel;
      assign sel = wr_en && (wr_idx == IDX_W'(i));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld[i] <= 1'b0;
         end else if (clr_all) begin
            vld[i] <= 1'b0;
         end else if (clr_local && !glob[i]) begin
            vld[i] <= 1'b0;
         end else if (clr_vec[i]) begin
            vld[i] <= 1'b0;
         end else if (sel) begin
            vld[i] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            glob[i]  <= 1'b0;
            tag[i]   <= '0;
            asn[i]   <= '0;
            ppn[i]   <= '0;
            rmask[i] <= '0;
            wmask[i] <= '0;
            frd[i]   <= 1'b0;
            fwr[i]   <= 1'b0;
         end else if (sel && !clr_all && !clr_local && !(|clr_vec)) begin
            glob[i]  <= wr_glob;
            tag[i]   <= wr_vpn;
            asn[i]   <= wr_asn;
            ppn[i]   <= wr_ppn;
            rmask[i] <= wr_rmask;
            wmask[i] <= wr_wmask;
            frd[i]   <= wr_frd;
            fwr[i]   <= wr_fwr;
         end
      end

      a_r8_keep_global: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_local && !clr_all && glob[i] && !clr_vec[i]) |=> vld[i] == $past(vld[i]));
      a_r9_cleared: assert property (@(posedge clk) disable iff (!rst_n)
         clr_vec[i] |=> !vld[i]);
   end

   a_r7_all_invalid: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> vld == '0);
   a_r5_slot_filled: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !clr_all && !clr_local && clr_vec == '0)
         |=> vld[$past(wr_idx)] && tag[$past(wr_idx)] == $past(wr_vpn));
endmodule

// File: rtl/tlb_asn_fa.sv
module tlb_asn_fa
   import tlb_asn_pkg::*;
#(
   parameter int ENTRIES = 8,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 16,
   parameter int ASN_W   = 8,
   parameter int OFS_W   = 13,
   parameter int MODES   = 4,
   parameter int IDX_W   = $clog2(ENTRIES),
   parameter int MODE_W  = (MODES > 1) ? $clog2(MODES) : 1
)(
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [VPN_W-1:0]       lk_vpn,
   input  logic [ASN_W-1:0]       lk_asn,
   input  logic [OFS_W-1:0]       lk_ofs,
   input  logic [MODE_W-1:0]      lk_mode,
   output logic                   lk_hit,
   output logic [IDX_W-1:0]       lk_idx,
   output logic [PPN_W-1:0]       lk_ppn,
   output logic [PPN_W+OFS_W-1:0] lk_paddr,
   output logic                   lk_glob,
   output logic [MODES-1:0]       lk_rmask,
   output logic [MODES-1:0]       lk_wmask,
   output logic                   lk_rd_ok,
   output logic                   lk_wr_ok,
   output logic                   lk_frd,
   output logic                   lk_fwr,
   input  logic                   ins_en,
   input  logic [VPN_W-1:0]       ins_vpn,
   input  logic [ASN_W-1:0]       ins_asn,
   input  logic                   ins_glob,
   input  logic [PPN_W-1:0]       ins_ppn,
   input  logic [MODES-1:0]       ins_rmask,
   input  logic [MODES-1:0]       ins_wmask,
   input  logic                   ins_frd,
   input  logic                   ins_fwr,
   input  logic [1:0]             cmd,
   input  logic [VPN_W-1:0]       cmd_vpn,
   input  logic [ASN_W-1:0]       cmd_asn,
   input  logic                   vic_adv,
   output logic [IDX_W-1:0]       vic_idx,
   output logic                   vic_valid,
   output logic [VPN_W-1:0]       vic_vpn,
   output logic [PPN_W-1:0]       vic_ppn
);
   if (ENTRIES < 2 || VPN_W < 1 || PPN_W < 1 || ASN_W < 1 || OFS_W < 1 || MODES < 1) begin : g_bad_cfg
      $error("tlb_asn_fa: illegal parameter set");
   end

   tlb_cmd_e cmd_e;
   logic     do_all, do_local, do_addr, idle, wr_go, ptr_step;

   assign cmd_e    = tlb_cmd_e'(cmd);
   assign do_all   = (cmd_e == TCMD_ALL);
   assign do_local = (cmd_e == TCMD_LOCAL);
   assign do_addr  = (cmd_e == TCMD_ADDR);
   assign idle     = (cmd_e == TCMD_NONE);
   assign wr_go    = idle && ins_en;
   assign ptr_step = idle && (ins_en || vic_adv);

   logic [ENTRIES-1:0]            vld, glob, frd, fwr;
   logic [ENTRIES-1:0][VPN_W-1:0] tag;
   logic [ENTRIES-1:0][ASN_W-1:0] asn;
   logic [ENTRIES-1:0][PPN_W-1:0] ppn;
   logic [ENTRIES-1:0][MODES-1:0] rmask, wmask;
   logic [ENTRIES-1:0]            lk_vec, fl_vec, fl_gated;
   logic [IDX_W-1:0]              ptr, first;
   logic                          any;

   tlb_victim_ptr #(.N(ENTRIES), .IDX_W(IDX_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .clr(do_all), .step(ptr_step), .ptr(ptr)
   );

   tlb_match_vec #(.N(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_lk_cmp (
      .vld(vld), .glob(glob), .tag(tag), .asn(asn),
      .q_vpn(lk_vpn), .q_asn(lk_asn), .hit_vec(lk_vec)
   );

   tlb_match_vec #(.N(ENTRIES), .VPN_W(VPN_W), .ASN_W(ASN_W)) u_fl_cmp (
      .vld(vld), .glob(glob), .tag(tag), .asn(asn),
      .q_vpn(cmd_vpn), .q_asn(cmd_asn), .hit_vec(fl_vec)
   );

   assign fl_gated = do_addr ? fl_vec : '0;

   tlb_first_hit #(.N(ENTRIES), .IDX_W(IDX_W)) u_first (
      .vec(lk_vec), .any(any), .idx(first)
   );

   tlb_entry_store #(
      .N(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASN_W(ASN_W),
      .MODES(MODES), .IDX_W(IDX_W)
   ) u_store (
      .clk(clk), .rst_n(rst_n),
      .clr_all(do_all), .clr_local(do_local), .clr_vec(fl_gated),
      .wr_en(wr_go), .wr_idx(ptr),
      .wr_vpn(ins_vpn), .wr_asn(ins_asn), .wr_glob(ins_glob), .wr_ppn(ins_ppn),
      .wr_rmask(ins_rmask), .wr_wmask(ins_wmask), .wr_frd(ins_frd), .wr_fwr(ins_fwr),
      .vld(vld), .glob(glob), .tag(tag), .asn(asn), .ppn(ppn),
      .rmask(rmask), .wmask(wmask), .frd(frd), .fwr(fwr)
   );

   always_comb begin
      lk_hit   = any;
      lk_idx   = any ? first : '0;
      lk_ppn   = any ? ppn[first] : '0;
      lk_glob  = any && glob[first];
      lk_rmask = any ? rmask[first] : '0;
      lk_wmask = any ? wmask[first] : '0;
      lk_frd   = any && frd[first];
      lk_fwr   = any && fwr[first];
      lk_paddr = any ? {ppn[first], lk_ofs} : '0;
      lk_rd_ok = 1'b0;
      lk_wr_ok = 1'b0;
      for (int m = 0; m < MODES; m++) begin
         if (any && lk_mode == MODE_W'(m)) begin
            lk_rd_ok = rmask[first][m];
            lk_wr_ok = wmask[first][m];
         end
      end
   end

   assign vic_idx   = ptr;
   assign vic_valid = vld[ptr];
   assign vic_vpn   = tag[ptr];
   assign vic_ppn   = ppn[ptr];

   a_r1_hit_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> vld[lk_idx] && tag[lk_idx] == lk_vpn);
   a_r1_hit_asn: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit && !lk_glob) |-> asn[lk_idx] == lk_asn);
   a_r5_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_go && ptr != IDX_W'(ENTRIES - 1)) |=> vic_idx == $past(ptr) + 1'b1);
   a_r12_reset_state: assert property (@(posedge clk)
      $past(!rst_n) && rst_n |-> vld == '0 && ptr == '0);
endmodule

// File: tb/tlb_asn_fa_tb.sv
module tlb_asn_fa_tb;
   localparam int CLK_PERIOD = 10;
   localparam int N = 8, VPN_W = 20, PPN_W = 16, ASN_W = 8, OFS_W = 13, MODES = 4;
   localparam int IDX_W = 3, MODE_W = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [VPN_W-1:0] lk_vpn = '0, ins_vpn = '0, cmd_vpn = '0;
   logic [ASN_W-1:0] lk_asn = '0, ins_asn = '0, cmd_asn = '0;
   logic [OFS_W-1:0] lk_ofs = '0;
   logic [MODE_W-1:0] lk_mode = '0;
   logic ins_en = 0, ins_glob = 0, ins_frd = 0, ins_fwr = 0, vic_adv = 0;
   logic [PPN_W-1:0] ins_ppn = '0;
   logic [MODES-1:0] ins_rmask = '0, ins_wmask = '0;
   logic [1:0] cmd = '0;
   logic lk_hit, lk_glob, lk_rd_ok, lk_wr_ok, lk_frd, lk_fwr, vic_valid;
   logic [IDX_W-1:0] lk_idx, vic_idx;
   logic [PPN_W-1:0] lk_ppn, vic_ppn;
   logic [PPN_W+OFS_W-1:0] lk_paddr;
   logic [MODES-1:0] lk_rmask, lk_wmask;
   logic [VPN_W-1:0] vic_vpn;

   tlb_asn_fa #(.ENTRIES(N), .VPN_W(VPN_W), .PPN_W(PPN_W), .ASN_W(ASN_W),
                .OFS_W(OFS_W), .MODES(MODES)) u_dut (
      .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_asn(lk_asn), .lk_ofs(lk_ofs),
      .lk_mode(lk_mode), .lk_hit(lk_hit), .lk_idx(lk_idx), .lk_ppn(lk_ppn),
      .lk_paddr(lk_paddr), .lk_glob(lk_glob), .lk_rmask(lk_rmask), .lk_wmask(lk_wmask),
      .lk_rd_ok(lk_rd_ok), .lk_wr_ok(lk_wr_ok), .lk_frd(lk_frd), .lk_fwr(lk_fwr),
      .ins_en(ins_en), .ins_vpn(ins_vpn), .ins_asn(ins_asn), .ins_glob(ins_glob),
      .ins_ppn(ins_ppn), .ins_rmask(ins_rmask), .ins_wmask(ins_wmask),
      .ins_frd(ins_frd), .ins_fwr(ins_fwr), .cmd(cmd), .cmd_vpn(cmd_vpn),
      .cmd_asn(cmd_asn), .vic_adv(vic_adv), .vic_idx(vic_idx), .vic_valid(vic_valid),
      .vic_vpn(vic_vpn), .vic_ppn(vic_ppn)
   );

   // behavioural reference state
   bit m_vld[N], m_glob[N], m_frd[N], m_fwr[N];
   int m_vpn[N], m_asn[N], m_ppn[N], m_rm[N], m_wm[N];
   int m_ptr;
   int n_tests = 0, n_fail = 0;
   string ptag = "R12";
   bit done = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic bit m_hit(input int i, input int vpn, input int asn);
      return m_vld[i] && m_vpn[i] == vpn && (m_glob[i] || m_asn[i] == asn);
   endfunction

   task automatic compare();
      int e = -1;
      for (int i = N - 1; i >= 0; i--) if (m_hit(i, int'(lk_vpn), int'(lk_asn))) e = i;
      chk(lk_hit == (e >= 0), {"R1/", ptag}, "hit", lk_hit, e >= 0);
      if (e >= 0) begin
         chk(int'(lk_idx) == e, {"R2/", ptag}, "idx", lk_idx, e);
         chk(int'(lk_ppn) == m_ppn[e] && lk_glob == m_glob[e] && lk_frd == m_frd[e]
             && lk_fwr == m_fwr[e] && int'(lk_rmask) == m_rm[e] && int'(lk_wmask) == m_wm[e],
             {"R2/", ptag}, "fields ppn", lk_ppn, m_ppn[e]);
         chk(lk_paddr == ((longint'(m_ppn[e]) << 13) | longint'(lk_ofs)), {"R3/", ptag},
             "paddr", lk_paddr, (longint'(m_ppn[e]) << 13) | longint'(lk_ofs));
         chk(lk_rd_ok == m_rm[e][lk_mode] && lk_wr_ok == m_wm[e][lk_mode], {"R4/", ptag},
             "mode bits", {lk_rd_ok, lk_wr_ok}, {m_rm[e][lk_mode], m_wm[e][lk_mode]});
      end else begin
         chk(lk_idx == '0 && lk_ppn == '0 && lk_paddr == '0 && !lk_rd_ok && !lk_wr_ok,
             {"R2/", ptag}, "miss zero", lk_paddr, 0);
      end
      chk(int'(vic_idx) == m_ptr, {"R11/", ptag}, "vic_idx", vic_idx, m_ptr);
      chk(vic_valid == m_vld[m_ptr], {"R11/", ptag}, "vic_valid", vic_valid, m_vld[m_ptr]);
      if (m_vld[m_ptr])
         chk(int'(vic_vpn) == m_vpn[m_ptr] && int'(vic_ppn) == m_ppn[m_ptr],
             {"R11/", ptag}, "vic_vpn", vic_vpn, m_vpn[m_ptr]);
   endtask

   task automatic model_update();
      case (cmd)
         2'd1: begin
            for (int i = 0; i < N; i++) m_vld[i] = 0;
            m_ptr = 0;
         end
         2'd2: for (int i = 0; i < N; i++) if (!m_glob[i]) m_vld[i] = 0;
         2'd3: begin
            bit kill[N];
            for (int i = 0; i < N; i++) kill[i] = m_hit(i, int'(cmd_vpn), int'(cmd_asn));
            for (int i = 0; i < N; i++) if (kill[i]) m_vld[i] = 0;
         end
         default: begin
            if (ins_en) begin
               m_vld[m_ptr] = 1; m_vpn[m_ptr] = int'(ins_vpn); m_asn[m_ptr] = int'(ins_asn);
               m_glob[m_ptr] = ins_glob; m_ppn[m_ptr] = int'(ins_ppn);
               m_rm[m_ptr] = int'(ins_rmask); m_wm[m_ptr] = int'(ins_wmask);
               m_frd[m_ptr] = ins_frd; m_fwr[m_ptr] = ins_fwr;
            end
            if (ins_en || vic_adv) m_ptr = (m_ptr + 1) % N;
         end
      endcase
   endtask

   // inputs are set at the falling edge before calling
   task automatic cyc();
      #1 compare();
      @(posedge clk);
      model_update();
      @(negedge clk);
      ins_en = 0; vic_adv = 0; cmd = 2'd0;
   endtask

   task automatic put(input int vpn, input int asn, input bit g, input int ppn);
      ins_en = 1; ins_vpn = VPN_W'(vpn); ins_asn = ASN_W'(asn); ins_glob = g;
      ins_ppn = PPN_W'(ppn); ins_rmask = MODES'(ppn); ins_wmask = MODES'(ppn >> 4);
      ins_frd = ppn[0]; ins_fwr = ppn[1];
   endtask

   task automatic look(input int vpn, input int asn);
      lk_vpn = VPN_W'(vpn); lk_asn = ASN_W'(asn);
      lk_ofs = OFS_W'($urandom); lk_mode = MODE_W'($urandom_range(0, MODES - 1));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected finish");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         m_vld[i] = 0; m_glob[i] = 0; m_frd[i] = 0; m_fwr[i] = 0;
         m_vpn[i] = 0; m_asn[i] = 0; m_ppn[i] = 0; m_rm[i] = 0; m_wm[i] = 0;
      end
      m_ptr = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R12: empty after reset, pointer at 0
      ptag = "R12"; look(5, 1); cyc();
      // R5 and R6: fill every slot, then two more to wrap
      ptag = "R5";
      for (int k = 0; k < N; k++) begin
         put(16 + k, k % 3, (k % 4) == 0, 'h100 + k * 37); look(16 + k - 1, 1); cyc();
      end
      ptag = "R6";
      put(40, 2, 0, 'h2a5); look(16, 0); cyc();
      put(41, 1, 1, 'h3c3); look(40, 2); cyc();
      // R1: local entry with wrong and right identifier, global with any
      ptag = "R1";
      look(40, 3); cyc();
      look(40, 2); cyc();
      look(41, 200); cyc();
      // R2: duplicate tag lands in a higher slot, lower one wins
      ptag = "R2";
      put(41, 7, 0, 'h777); look(41, 7); cyc();
      look(41, 7); cyc();
      // R10: command and write in one cycle, write dropped
      ptag = "R10";
      cmd = 2'd3; cmd_vpn = 20'd99; cmd_asn = 8'd0; put(50, 1, 0, 'h55); vic_adv = 1;
      look(50, 1); cyc();
      look(50, 1); cyc();
      // R11: step the pointer only
      ptag = "R11";
      vic_adv = 1; look(18, 2); cyc();
      put(60, 1, 0, 'h66); vic_adv = 1; look(60, 1); cyc();
      look(60, 1); cyc();
      // R9: clear by address through a global and a local match
      ptag = "R9";
      cmd = 2'd3; cmd_vpn = 20'd41; cmd_asn = 8'd7; look(41, 7); cyc();
      look(41, 7); cyc();
      look(41, 1); cyc();
      // R8: clear local keeps globals
      ptag = "R8";
      cmd = 2'd2; look(20, 0); cyc();
      look(20, 0); cyc();
      look(16, 9); cyc();
      // R7: clear all
      ptag = "R7";
      cmd = 2'd1; look(20, 0); cyc();
      look(20, 0); cyc();
      // random traffic, compared against the model every cycle
      ptag = "RND";
      for (int t = 0; t < 4000; t++) begin
         int r = $urandom_range(0, 99);
         if (r < 40) put($urandom_range(0, 5), $urandom_range(0, 2), $urandom_range(0, 3) == 0,
                         $urandom_range(0, 65535));
         if (r >= 40 && r < 48) vic_adv = 1;
         if (r >= 48 && r < 51) cmd = 2'd3;
         if (r == 51) cmd = 2'd2;
         if (r == 52) cmd = 2'd1;
         if (r >= 53 && r < 56) begin cmd = 2'd3; vic_adv = 1; end
         cmd_vpn = VPN_W'($urandom_range(0, 5)); cmd_asn = ASN_W'($urandom_range(0, 2));
         look($urandom_range(0, 5), $urandom_range(0, 2));
         cyc();
      end
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule